// File: doc/BRIEF.md
# Line Delay with Enable Replay

This block holds one video line in a line memory and plays it back during the line that follows. Each clock of a line stores the input word together with its write-enable bit. During the next line the same clock slot is read back and driven onto the output. Any gaps in the input enable therefore come out again with exactly the same spacing. The output enable is a stored copy of the input enable, not a strobe the block makes up. A line starts on the first enabled clock that follows a run of disabled clocks. The length of each line is measured from one start to the next, and that length limits how far the following line may read back.

A vertical blanking level enters asynchronously and is passed through a two-stage synchronizer. While it is high the memory keeps being written, but the output enable is held low. After it falls, the output stays blanked through one more line. That line carries the last line of the old field, so the last line of each field is never shown. A static select pin can delay the output data by one clock relative to the output enable, to suit the memory that follows.

The stream is line-locked and cannot be stalled, so there is no ready signal. `in_valid` marks active input samples and `out_valid` marks active output samples. The downstream side must accept every clock in which `out_valid` is high.

Top module: `line_delay_replay`

## Requirements
- R1: A line starts on a clock with `in_valid` high that follows at least GAP_MIN (4) consecutive clocks with `in_valid` low. Shorter low runs, for example 3 clocks, stay inside the current line.
- R2: Take clock k of a line, counting from 0 at the line start. One clock after it, `out_valid` and `out_data` show the `in_valid` and `in_data` values of clock k of the previous line.
- R3: The replayed enable is a copy of the previous line's enable that is exact to the clock, including single-clock holes and the low tail at the end of the line.
- R4: A slot at or beyond the previous line's length gives `out_valid` 0 and `out_data` 0. This also covers the whole first line after reset, which has no previous line.
- R5: At most DEPTH (1024) clocks of a line are stored. A longer line counts as DEPTH long, and its clocks past DEPTH are not stored.
- R6: `vblank_async` passes through two flip-flops. While the synchronized level is high, `out_valid` is 0. After the level falls, `out_valid` stays 0 through the first line that starts. It is released from the start of the second line onward. Writing goes on throughout.
- R7: With `data_lag` = 0, `out_data` lines up with `out_valid`. With `data_lag` = 1, `out_data` shows the value that would have been shown one clock earlier.
- R8: While `rst_n` is low, and right after it rises, `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic acts on its rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input write enable; marks active samples and, through its gaps, line starts |
| in_data | input | DW | Input sample word |
| vblank_async | input | 1 | Asynchronous vertical blanking level, active high |
| data_lag | input | 1 | 0: output data lines up with the output enable; 1: data one clock later |
| out_valid | output | 1 | Replayed write enable of the previous line |
| out_data | output | DW | Replayed sample word of the previous line |

## Verification
Lines of equal length with no holes show the plain one-line delay. Lines with single-clock holes, and lines with a three-clock hole in the middle, tell apart a true copy of the enable from a regenerated strobe, and a real line start from a hole. Lengths that rise and fall, plus one line longer than the memory, check reading past the previous line's end and the storage cap. A blanking pulse lasting two lines, and a run with the data lag switched on, check the field-boundary mask and the one-clock data offset. The bench model reaches its expected values without reference to the design.

// File: rtl/lm_pkg.sv
package lm_pkg;
  // States of the field-boundary blanking control
  typedef enum logic [1:0] {
    BLK_OPEN  = 2'd0,  // replay passes through
    BLK_HOLD  = 2'd1,  // blanking level seen, waiting for first line start
    BLK_FIRST = 2'd2   // first line of new field running, still blanked
  } blank_state_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/lm_line_timer.sv
module lm_line_timer #(
  parameter int DEPTH   = 1024,
  parameter int GAP_MIN = 4,
  parameter int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          line_start,
  output logic [CW-1:0] slot_addr,
  output logic [CW-1:0] replay_len,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] prev_len
);
  localparam int GW = $clog2(GAP_MIN + 1);
  localparam logic [GW-1:0] GAP_W   = GW'(GAP_MIN);
  localparam logic [CW-1:0] DEPTH_W = CW'(DEPTH);

  logic [GW-1:0] low_run;
  logic          have_line;

  assign line_start = in_valid && (low_run == GAP_W);
  assign slot_addr  = line_start ? '0 : cnt;
  assign replay_len = line_start ? (have_line ? cnt : '0) : prev_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (in_valid) begin
      low_run <= '0;
    end else if (low_run != GAP_W) begin
      low_run <= low_run + GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      prev_len  <= '0;
      have_line <= 1'b0;
    end else if (line_start) begin
      prev_len  <= have_line ? cnt : '0;
      have_line <= 1'b1;
      cnt       <= CW'(1);
    end else if (cnt != DEPTH_W) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/lm_blank_gate.sv
module lm_blank_gate
  import lm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vblank_async,
  input  logic line_start,
  output logic vs_level,
  output logic blank_now
);
  logic [SYNC_STAGES-1:0] sync_q;
  blank_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], vblank_async};
  end

  assign vs_level = sync_q[SYNC_STAGES-1];

  always_comb begin
    state_d = state_q;
    if (vs_level) begin
      state_d = BLK_HOLD;
    end else if (line_start) begin
      case (state_q)
        BLK_HOLD:  state_d = BLK_FIRST;
        BLK_FIRST: state_d = BLK_OPEN;
        default:   state_d = state_q;
      endcase
    end
  end

  assign blank_now = (state_d != BLK_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BLK_OPEN;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/lm_line_ram.sv
module lm_line_ram #(
  parameter int DEPTH = 1024,
  parameter int WW    = 13,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [WW-1:0] wr_slot,
  output logic [WW-1:0] rd_slot
);
  logic [WW-1:0] mem [DEPTH];

  // read returns the previous line's content before this clock's write
  assign rd_slot = mem[addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_slot;
  end
endmodule

// File: rtl/lm_out_align.sv
module lm_out_align #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_hit,
  input  logic          slot_en,
  input  logic [DW-1:0] slot_data,
  input  logic          blank_now,
  input  logic          data_lag,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [DW-1:0] stage_data
);
  logic [DW-1:0] late_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      stage_data <= '0;
      late_data  <= '0;
    end else begin
      out_valid  <= slot_hit && slot_en && !blank_now;
      stage_data <= slot_hit ? slot_data : '0;
      late_data  <= stage_data;
    end
  end

  assign out_data = data_lag ? late_data : stage_data;
endmodule

// File: rtl/line_delay_replay.sv
module line_delay_replay #(
  parameter int DW      = 12,
  parameter int DEPTH   = 1024,
  parameter int GAP_MIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          vblank_async,
  input  logic          data_lag,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WW = DW + 1;

  logic          line_start;
  logic [CW-1:0] slot_addr, replay_len, cnt_w, prev_len_w;
  logic          vs_level, blank_now, wr_en, rd_hit;
  logic [WW-1:0] rd_slot;
  logic [DW-1:0] stage_data;

  lm_line_timer #(.DEPTH(DEPTH), .GAP_MIN(GAP_MIN), .CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .line_start(line_start), .slot_addr(slot_addr), .replay_len(replay_len),
    .cnt(cnt_w), .prev_len(prev_len_w)
  );

  lm_blank_gate gate_i (
    .clk(clk), .rst_n(rst_n), .vblank_async(vblank_async),
    .line_start(line_start), .vs_level(vs_level), .blank_now(blank_now)
  );

  assign wr_en  = slot_addr < CW'(DEPTH);
  assign rd_hit = slot_addr < replay_len;

  lm_line_ram #(.DEPTH(DEPTH), .WW(WW), .AW(AW)) ram_i (
    .clk(clk), .wr_en(wr_en), .addr(slot_addr[AW-1:0]),
    .wr_slot({in_valid, in_data}), .rd_slot(rd_slot)
  );

  lm_out_align #(.DW(DW)) align_i (
    .clk(clk), .rst_n(rst_n), .slot_hit(rd_hit), .slot_en(rd_slot[DW]),
    .slot_data(rd_slot[DW-1:0]), .blank_now(blank_now), .data_lag(data_lag),
    .out_valid(out_valid), .out_data(out_data), .stage_data(stage_data)
  );
endmodule

// File: rtl/lm_checker.sv
module lm_checker #(
  parameter int DEPTH = 1024,
  parameter int CW    = 11,
  parameter int DW    = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          line_start,
  input logic          rd_hit,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] prev_len,
  input logic          vs_level,
  input logic          data_lag,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic [DW-1:0] stage_data
);
  localparam logic [CW-1:0] DEPTH_W = CW'(DEPTH);

  // R1
  r1_start_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (in_valid && !$past(in_valid)));

  // R4
  r4_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rd_hit));

  // R5
  r5_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= DEPTH_W) && (prev_len <= DEPTH_W));

  // R6
  r6_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_level |=> !out_valid);

  // R7
  r7_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_lag |-> (out_data == $past(stage_data)));
endmodule

bind line_delay_replay lm_checker #(.DEPTH(DEPTH), .CW(CW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .line_start(line_start),
  .rd_hit(rd_hit), .cnt(cnt_w), .prev_len(prev_len_w), .vs_level(vs_level),
  .data_lag(data_lag), .out_valid(out_valid), .out_data(out_data),
  .stage_data(stage_data)
);

// File: tb/line_delay_replay_tb_top.sv
`timescale 1ns/1ps
module line_delay_replay_tb_top;
  localparam int DW    = 12;
  localparam int DEPTH = 1024;
  localparam int GAP   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic vblank = 1'b0;
  logic data_lag = 1'b0;
  logic out_valid;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;

  line_delay_replay #(.DW(DW), .DEPTH(DEPTH), .GAP_MIN(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .vblank_async(vblank), .data_lag(data_lag),
    .out_valid(out_valid), .out_data(out_data)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  string tag = "R2";
  int seen_valid = 0;

  // reference model state
  int low_run_m = 0;
  bit have_m = 1'b0;
  int cur[$];
  int prv[$];
  bit s1m = 1'b0, s2m = 1'b0;
  int blk_m = 0;          // 0 open, 1 hold, 2 first line of field
  bit exp_v = 1'b0;
  int exp_d1 = 0, exp_d2 = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic step(input bit iv, input logic [DW-1:0] d, input bit vb, input bit lg);
    bit st, hit, blank;
    int k, slot, expd;
    in_valid = iv; in_data = d; vblank = vb; data_lag = lg;
    st = iv && (low_run_m >= GAP);
    if (st) begin
      if (have_m) prv = cur; else prv.delete();
      cur.delete();
      have_m = 1'b1;
    end
    k = cur.size();
    hit = (k < prv.size());
    slot = hit ? prv[k] : 0;
    if (s2m) blk_m = 1;
    else if (st && blk_m == 1) blk_m = 2;
    else if (st && blk_m == 2) blk_m = 0;
    blank = (blk_m != 0);
    exp_d2 = exp_d1;
    exp_v  = hit && slot[DW] && !blank;
    exp_d1 = hit ? (slot & ((1 << DW) - 1)) : 0;
    if (k < DEPTH) cur.push_back((int'(iv) << DW) | int'(d));
    low_run_m = iv ? 0 : ((low_run_m < GAP) ? low_run_m + 1 : GAP);
    s2m = s1m; s1m = vb;
    @(negedge clk);
    expd = lg ? exp_d2 : exp_d1;
    check((out_valid === exp_v) && (out_data === DW'(expd)), tag,
          (int'(out_valid) << DW) | int'(out_data), (int'(exp_v) << DW) | expd);
    if (out_valid) seen_valid++;
  endtask

  // active clocks, optional single holes every 'holes', optional 3-clock hole mid-line
  task automatic send_line(input int active, input int holes, input bit gap3,
                           input int tail, input bit vb_act, input bit vb_tail, input bit lg);
    for (int i = 0; i < active; i++) begin
      bit en = 1'b1;
      if (holes > 0 && i > 0 && (i % holes) == 0) en = 1'b0;
      if (gap3 && i >= active / 2 && i < active / 2 + 3) en = 1'b0;
      step(en, DW'($urandom), vb_act, lg);
    end
    for (int i = 0; i < tail; i++) step(1'b0, DW'($urandom), vb_tail, lg);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R8: reset state while held and just after release
    check(out_valid === 1'b0 && out_data === '0, "R8", int'(out_valid), 0);
    rst_n = 1'b1;
    check(out_valid === 1'b0 && out_data === '0, "R8", int'(out_data), 0);
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b0, 1'b0);

    // R4: first line after reset has nothing to replay
    tag = "R4"; seen_valid = 0;
    send_line(40, 0, 1'b0, 6, 1'b0, 1'b0, 1'b0);
    check(seen_valid == 0, "R4", seen_valid, 0);

    // R2: plain one-line delay
    tag = "R2";
    for (int n = 0; n < 3; n++) send_line(40, 0, 1'b0, 6, 1'b0, 1'b0, 1'b0);

    // R3: holes are replayed clock-exactly
    tag = "R3";
    for (int n = 0; n < 3; n++) send_line(48, 5, 1'b0, 5, 1'b0, 1'b0, 1'b0);

    // R1: a 3-clock low run does not start a line
    tag = "R1";
    for (int n = 0; n < 3; n++) send_line(44, 0, 1'b1, 4, 1'b0, 1'b0, 1'b0);

    // R4: lengths rise and fall
    tag = "R4";
    send_line(60, 7, 1'b0, 6, 1'b0, 1'b0, 1'b0);
    send_line(20, 0, 1'b0, 6, 1'b0, 1'b0, 1'b0);
    send_line(50, 3, 1'b0, 8, 1'b0, 1'b0, 1'b0);
    send_line(50, 0, 1'b0, 6, 1'b0, 1'b0, 1'b0);

    // R7: data one clock behind the enable
    tag = "R7";
    for (int n = 0; n < 3; n++) send_line(40, 6, 1'b0, 6, 1'b0, 1'b0, 1'b1);

    // R6: blanking level for two lines, falling in the last tail
    tag = "R6";
    send_line(40, 0, 1'b0, 6, 1'b1, 1'b1, 1'b0);
    send_line(40, 0, 1'b0, 6, 1'b1, 1'b0, 1'b0);
    seen_valid = 0;
    send_line(40, 0, 1'b0, 6, 1'b0, 1'b0, 1'b0);
    check(seen_valid == 0, "R6", seen_valid, 0);
    seen_valid = 0;
    send_line(40, 0, 1'b0, 6, 1'b0, 1'b0, 1'b0);
    check(seen_valid == 40, "R6", seen_valid, 40);

    // R5: lines longer than the memory
    tag = "R5";
    send_line(1100, 9, 1'b0, 6, 1'b0, 1'b0, 1'b0);
    seen_valid = 0;
    send_line(1100, 0, 1'b0, 6, 1'b0, 1'b0, 1'b0);
    check(seen_valid > 0 && seen_valid < 1024, "R5", seen_valid, 1024);
    send_line(30, 0, 1'b0, 6, 1'b0, 1'b0, 1'b0);
    send_line(30, 0, 1'b0, 6, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule